// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for one load or store and, when the addressing mode asks for it, the updated value of the base register. Each request carries a 32-bit base value, a 4-bit addressing-mode code, a 2-bit access size, a 32-bit register offset and a 5-bit unsigned immediate offset. The mode code picks which offset is used and whether that offset is added or subtracted. It also picks the form of the access: a plain offset that leaves the base alone, a pre-modify that accesses at the moved address, or a post-modify that accesses at the old base.

The selected offset is widened to 32 bits and scaled by the access size. It is then applied to the base with wrap-around arithmetic. All results are registered and appear one cycle after the request, qualified by a valid strobe. The surrounding pipeline writes `out_base` back to the base register only when `out_wb` is high. It traps on `out_illegal`.

Top module: `lsag_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid`, `out_wb` and `out_illegal` are 0.
- R2: `out_valid` equals the value that `in_valid` had one clock earlier.
- R3: Mode bit 2 selects the offset source: 1 selects `in_ofs_reg`, and 0 selects `in_ofs_imm` zero-extended to 32 bits.
- R4: The selected offset is shifted left by 0 bits for size code 00 (byte), by 1 bit for 01 (halfword), and by 2 bits for 10 (word) and 11.
- R5: Mode bit 0 picks the direction: 1 adds the scaled offset to the base and 0 subtracts it.
- R6: Plain form (mode bit 3 = 0, bit 1 = 0): `out_addr` is the base moved by the scaled offset, `out_base` is the unchanged base, and `out_wb` is 0.
- R7: Pre-modify form (bit 3 = 1, bit 1 = 0): `out_addr` and `out_base` both equal the moved base, and `out_wb` is 1.
- R8: Post-modify form (bit 3 = 1, bit 1 = 1): `out_addr` is the unchanged base, `out_base` is the moved base, and `out_wb` is 1.
- R9: All address arithmetic wraps modulo 2^32.
- R10: Codes with bit 3 = 0 and bit 1 = 1 (0010, 0011, 0110, 0111) raise `out_illegal`. For these codes `out_wb` is 0, and `out_addr` and `out_base` both equal the unchanged base.
- R11: A cycle with `in_valid` low produces `out_wb` = 0 and `out_illegal` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 4 | Addressing-mode code |
| in_size | input | 2 | Access size code |
| in_base | input | 32 | Base register value |
| in_ofs_reg | input | 32 | Register offset value |
| in_ofs_imm | input | 5 | Unsigned immediate offset |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_addr | output | 32 | Effective address |
| out_base | output | 32 | Updated base value |
| out_wb | output | 1 | Base write-back enable |
| out_illegal | output | 1 | Unused mode code seen |

## Verification
The bench sweeps all sixteen mode codes against every size code, for bases and register offsets chosen near zero, near the top of the address space and at the sign boundary. It compares every output with arithmetic computed from the requirements.

Several faults stand out in this sweep. A design that swapped the pre and post forms would show the base where the moved address belongs. One that wrote back on plain offsets would corrupt the base register. One that sign-extended the immediate, or scaled it by the wrong amount, would give addresses off by a multiple of the access size. Directed cases also cover wrap-around past 0xFFFFFFFC and below zero, unused codes that must not write back, and idle cycles that must stay silent.

// File: rtl/lsag_pkg.sv
// Shared types for the load/store address generator.
// Assumes the 4-bit mode layout: bit 3 modify, bit 2 register offset,
// bit 1 post (modify) or reserved (plain), bit 0 add.
package lsag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        FORM_PLAIN = 2'b00,
        FORM_PRE   = 2'b01,
        FORM_POST  = 2'b10,
        FORM_BAD   = 2'b11
    } form_e;

    typedef struct packed {
        logic  use_reg;
        logic  add;
        form_e form;
    } mode_s;

endpackage

// File: rtl/lsag_mode_decode.sv
// Splits the 4-bit addressing-mode code into offset source, direction and
// access form. Purely combinational; assumes the bit layout in lsag_pkg.
module lsag_mode_decode
    import lsag_pkg::*;
(
    input  logic [3:0] mode,
    output mode_s      dec
);

    // Map the code bits onto the decoded fields.
    always_comb begin
        dec.use_reg = mode[2];
        dec.add     = mode[0];
        unique case ({mode[3], mode[1]})
            2'b00:   dec.form = FORM_PLAIN;
            2'b01:   dec.form = FORM_BAD;
            2'b10:   dec.form = FORM_PRE;
            default: dec.form = FORM_POST;
        endcase
    end

endmodule

// File: rtl/lsag_offset_scaler.sv
// Picks the register or immediate offset, zero-extends the immediate and
// shifts by the access size. Assumes size codes 2 and 3 both mean four bytes.
module lsag_offset_scaler #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic              use_reg,
    input  logic [ADDR_W-1:0] ofs_reg,
    input  logic [IMM_W-1:0]  ofs_imm,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] scaled
);

    localparam int NUM_SIZE = 4;
    localparam int MAX_SH   = 2;

    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] cand [NUM_SIZE];

    // Choose the offset source; the immediate is widened with zeros.
    always_comb begin
        raw = use_reg ? ofs_reg : {{(ADDR_W-IMM_W){1'b0}}, ofs_imm};
    end

    // One shifted candidate per size code.
    for (genvar g = 0; g < NUM_SIZE; g++) begin : g_scale
        localparam int SH = (g > MAX_SH) ? MAX_SH : g;
        assign cand[g] = raw << SH;
    end

    // Select the candidate for the requested size.
    always_comb begin
        scaled = cand[size];
    end

endmodule

// File: rtl/lsag_addr_core.sv
// Applies the scaled offset to the base and routes the results by access
// form: effective address, new base, write-back and illegal flag.
// Combinational; the arithmetic wraps at ADDR_W bits.
module lsag_addr_core
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] scaled,
    input  mode_s             dec,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] new_base,
    output logic              wb,
    output logic              illegal
);

    logic [ADDR_W-1:0] moved;

    // Move the base up or down by the scaled offset.
    always_comb begin
        moved = dec.add ? (base + scaled) : (base - scaled);
    end

    // Route the results according to the access form.
    always_comb begin
        addr     = base;
        new_base = base;
        wb       = 1'b0;
        illegal  = 1'b0;
        unique case (dec.form)
            FORM_PLAIN: addr = moved;
            FORM_PRE: begin
                addr     = moved;
                new_base = moved;
                wb       = 1'b1;
            end
            FORM_POST: begin
                new_base = moved;
                wb       = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsag_top.sv
// Load/store address generator top. Decodes the mode, scales the offset,
// forms address and new base, and registers everything with one cycle of
// latency. Write-back and illegal flags are qualified by the request strobe.
// Assumes a synchronous active-low reset.
module lsag_top
    import lsag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_mode,
    input  logic [1:0]        in_size,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] in_ofs_reg,
    input  logic [IMM_W-1:0]  in_ofs_imm,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_base,
    output logic              out_wb,
    output logic              out_illegal
);

    mode_s             dec;
    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] base_c;
    logic              wb_c;
    logic              bad_c;

    lsag_mode_decode u_dec (
        .mode (in_mode),
        .dec  (dec)
    );

    lsag_offset_scaler #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_scale (
        .use_reg (dec.use_reg),
        .ofs_reg (in_ofs_reg),
        .ofs_imm (in_ofs_imm),
        .size    (in_size),
        .scaled  (scaled)
    );

    lsag_addr_core #(
        .ADDR_W (ADDR_W)
    ) u_core (
        .base     (in_base),
        .scaled   (scaled),
        .dec      (dec),
        .addr     (addr_c),
        .new_base (base_c),
        .wb       (wb_c),
        .illegal  (bad_c)
    );

    // Output register stage with qualified flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_base    <= '0;
            out_wb      <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_addr    <= addr_c;
            out_base    <= base_c;
            out_wb      <= in_valid & wb_c;
            out_illegal <= in_valid & bad_c;
        end
    end

endmodule

// File: rtl/lsag_top_checker.sv
// Temporal checks on the ports of lsag_top, attached by bind.
module lsag_top_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_mode,
    input logic [ADDR_W-1:0] in_base,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] out_base,
    input logic              out_wb,
    input logic              out_illegal
);

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wb && !out_illegal));

    assert_plain_keeps_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[3] && !in_mode[1]) |=> (!out_wb && out_base == $past(in_base)));

    assert_pre_addr_is_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[3] && !in_mode[1]) |=> (out_wb && out_addr == out_base));

    assert_post_old_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[3] && in_mode[1]) |=> (out_wb && out_addr == $past(in_base)));

    assert_bad_code_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[3] && in_mode[1]) |=> (out_illegal && !out_wb && out_addr == $past(in_base)));

    assert_illegal_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_wb);

endmodule

bind lsag_top lsag_top_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_mode     (in_mode),
    .in_base     (in_base),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_base    (out_base),
    .out_wb      (out_wb),
    .out_illegal (out_illegal)
);

// File: tb/lsag_top_test.sv
// Self-checking bench: mode x size x operand sweep plus directed corners.
module lsag_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_mode = '0;
    logic [1:0]  in_size = '0;
    logic [31:0] in_base = '0;
    logic [31:0] in_ofs_reg = '0;
    logic [4:0]  in_ofs_imm = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_base;
    logic        out_wb;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lsag_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_mode     (in_mode),
        .in_size     (in_size),
        .in_base     (in_base),
        .in_ofs_reg  (in_ofs_reg),
        .in_ofs_imm  (in_ofs_imm),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_base    (out_base),
        .out_wb      (out_wb),
        .out_illegal (out_illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; results are sampled at the following one.
    task automatic apply(input logic v, input logic [3:0] m, input logic [1:0] s,
                         input logic [31:0] b, input logic [31:0] r, input logic [4:0] i);
        @(negedge clk);
        in_valid = v; in_mode = m; in_size = s;
        in_base = b; in_ofs_reg = r; in_ofs_imm = i;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] bases [4];
        logic [31:0] regs [4];
        logic [4:0]  imms [4];
        bases = '{32'h0000_0000, 32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0004};
        regs  = '{32'h0000_0000, 32'h0000_0003, 32'h4000_0001, 32'hFFFF_FFFF};
        imms  = '{5'd0, 5'd31, 5'd5, 5'd16};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 out_wb", {31'b0, out_wb}, 32'd0);
        chk("R1 out_illegal", {31'b0, out_illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle out_valid", {31'b0, out_valid}, 32'd0);

        // R3: register offset chosen over immediate (byte)
        apply(1, 4'b0101, 2'b00, 32'h100, 32'd7, 5'd3);
        chk("R3 reg offset addr", out_addr, 32'h107);
        apply(1, 4'b0001, 2'b00, 32'h100, 32'd7, 5'd3);
        chk("R3 imm offset addr", out_addr, 32'h103);
        // R4: scaling per size code
        apply(1, 4'b0001, 2'b01, 32'h100, 32'd0, 5'd3);
        chk("R4 half scale", out_addr, 32'h106);
        apply(1, 4'b0001, 2'b10, 32'h100, 32'd0, 5'd3);
        chk("R4 word scale", out_addr, 32'h10C);
        apply(1, 4'b0001, 2'b11, 32'h100, 32'd0, 5'd3);
        chk("R4 size 11 scale", out_addr, 32'h10C);
        // R5: subtract direction
        apply(1, 4'b0000, 2'b00, 32'h100, 32'd0, 5'd3);
        chk("R5 negative addr", out_addr, 32'hFD);
        // R9: wrap above and below
        apply(1, 4'b1001, 2'b10, 32'hFFFF_FFFC, 32'd0, 5'd2);
        chk("R9 wrap up addr", out_addr, 32'h4);
        chk("R9 wrap up base", out_base, 32'h4);
        apply(1, 4'b1110, 2'b00, 32'h1, 32'd2, 5'd0);
        chk("R9 wrap down base", out_base, 32'hFFFF_FFFF);
        // R11: idle cycle with a modify code
        apply(0, 4'b1101, 2'b10, 32'h200, 32'd4, 5'd1);
        chk("R11 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11 idle out_wb", {31'b0, out_wb}, 32'd0);
        apply(0, 4'b0010, 2'b10, 32'h200, 32'd4, 5'd1);
        chk("R11 idle out_illegal", {31'b0, out_illegal}, 32'd0);

        // Sweep: R2, R6, R7, R8, R10
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [3:0]  mc;
                        logic [31:0] ofs, sc, mv, e_addr, e_base;
                        logic        e_wb, e_bad;
                        string       tag;
                        mc  = 4'(m);
                        ofs = mc[2] ? regs[k] : {27'b0, imms[k]};
                        sc  = ofs << ((s >= 2) ? 2 : s);
                        mv  = mc[0] ? bases[b] + sc : bases[b] - sc;
                        case ({mc[3], mc[1]})
                            2'b00: begin tag = "R6"; e_addr = mv; e_base = bases[b]; e_wb = 0; e_bad = 0; end
                            2'b01: begin tag = "R10"; e_addr = bases[b]; e_base = bases[b]; e_wb = 0; e_bad = 1; end
                            2'b10: begin tag = "R7"; e_addr = mv; e_base = mv; e_wb = 1; e_bad = 0; end
                            default: begin tag = "R8"; e_addr = bases[b]; e_base = mv; e_wb = 1; e_bad = 0; end
                        endcase
                        apply(1, mc, 2'(s), bases[b], regs[k], imms[k]);
                        chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
                        chk({tag, " addr"}, out_addr, e_addr);
                        chk({tag, " base"}, out_base, e_base);
                        chk({tag, " wb"}, {31'b0, out_wb}, {31'b0, e_wb});
                        chk({tag, " illegal"}, {31'b0, out_illegal}, {31'b0, e_bad});
                    end
                end
            end
        end

        apply(0, 4'b0000, 2'b00, 32'h0, 32'h0, 5'd0);
        chk("R2 drop out_valid", {31'b0, out_valid}, 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as one failed check.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule